// File: doc/BRIEF.md
# Strobed Angle Vector Rotator

This block turns a stream of signed orthogonal sample pairs (d, q) through a digitally supplied angle and emits the rotated pair: d' = d·cos θ − q·sin θ and q' = d·sin θ + q·cos θ. The angle is a 12-bit binary fraction of a full turn, so there are 4096 steps per revolution. A controller or position sensor hands a new angle over with a strobe pulse. The pulse's rising edge captures the word. Its falling edge starts a coefficient setup interval, and `busy_o` is high for that whole interval. When `busy_o` drops, the new sine and cosine coefficients take over, and every sample after that is rotated with them.

The coefficients come from an internal quarter-wave sine table. The two top angle bits select the quadrant symmetry and the signs. Products are rounded back to the sample width and saturated. The output valid flag is the input valid flag delayed by a fixed two-cycle latency. To rotate in the reverse direction (by −θ), the caller supplies the two's-complement negative of the angle. A strobe that arrives while a setup is still in progress is discarded, and a sticky overrun flag records the event.

Top module: `park_rotator`

## Requirements
- R1: Immediately after reset, `busy_o`, `overrun_o` and `out_valid_o` are low. The held rotation is angle 0 (cos = 32767/32768, sin = 0), so every output equals its input to within rounding.
- R2: The angle word on `angle_i` (`angle_i[11]` is the most significant bit, one LSB = 360°/4096) is captured on the clock where `strobe_i` is first seen high. A change on `angle_i` later in the same pulse has no effect.
- R3: `busy_o` rises in the cycle after the clock edge that first samples `strobe_i` low after an accepted pulse. It then stays high for exactly BUSY_CYC cycles.
- R4: A strobe pulse that is sampled high on fewer than MIN_HI_CYC clock edges starts no conversion: `busy_o` stays low and the rotation angle is unchanged. A pulse of exactly MIN_HI_CYC edges is accepted.
- R5: A strobe rising edge seen while `busy_o` is high is ignored. Its angle never reaches the coefficients, its falling edge starts nothing, and `overrun_o` goes high and stays high until reset.
- R6: While `busy_o` is high, samples are rotated with the previous coefficients. The new angle applies from the first cycle after `busy_o` falls.
- R7: Each rotated output equals the rotation formula in all four quadrants. The formula uses coefficients round(32767·sin θ) and round(32767·cos θ), and the result is within 2 LSB.
- R8: Each result is rounded as (sum + 2^14) >> 15 and saturated to the range −32768 to 32767.
- R9: `out_valid_o` equals `in_valid_i` delayed by exactly two clock cycles, and `d_o`/`q_o` are valid in that cycle.
- R10: Loading the angle 4096 − a rotates by −a·360°/4096, which is the reverse transform.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| angle_i | input | 12 | Angle word, bit 11 most significant |
| strobe_i | input | 1 | Angle strobe, synchronous to clk |
| busy_o | output | 1 | Coefficient setup in progress |
| overrun_o | output | 1 | Sticky: strobe arrived during setup |
| in_valid_i | input | 1 | Input sample valid |
| d_i | input | 16 | Signed real-axis input |
| q_i | input | 16 | Signed imaginary-axis input |
| out_valid_o | output | 1 | Output sample valid |
| d_o | output | 16 | Signed rotated real-axis output |
| q_o | output | 16 | Signed rotated imaginary-axis output |

## Verification
The rotation is tested with vectors of mixed signs at angles in every quadrant. Some angles fall exactly on quadrant boundaries, which exercises the table mirroring and the zero-index cosine special case. Others are off-axis, which exercises both table lookups. Full-scale vectors at 45° separate correct saturation from wrap-around. A negated angle shows that the sign handling of the quadrant map gives a true inverse. On the handshake side, the tests cover a pulse one cycle short of the minimum width, a pulse of exactly the minimum width, an angle change inside a pulse, and a second strobe during setup. Together these tell apart the capture timing, the width filter, and the lockout, each of which the bench observes through `busy_o`, `overrun_o` and the rotated data.

// File: rtl/rot_pkg.sv
`timescale 1ns/1ps
// Package: shared quadrant encoding for the vector rotator.
// Assumes the two most significant angle bits select the quadrant.
package rot_pkg;
    typedef enum logic [1:0] {
        QUAD_0   = 2'd0,
        QUAD_90  = 2'd1,
        QUAD_180 = 2'd2,
        QUAD_270 = 2'd3
    } quad_e;
endpackage

// File: rtl/rot_strobe_ctrl.sv
`timescale 1ns/1ps
// Module: rot_strobe_ctrl
// Captures the angle on the strobe rising edge, filters short pulses,
// runs the busy interval after an accepted falling edge, and flags
// strobes that arrive during busy. Assumes strobe_i is synchronous to clk.
module rot_strobe_ctrl #(
    parameter int ANG_W      = 12,
    parameter int BUSY_CYC   = 400,
    parameter int MIN_HI_CYC = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ANG_W-1:0] angle_i,
    input  logic             strobe_i,
    output logic [ANG_W-1:0] conv_ang_o,
    output logic             busy_o,
    output logic             load_o,
    output logic             overrun_o
);
    localparam int BC_W = $clog2(BUSY_CYC + 1);
    localparam int HI_W = $clog2(MIN_HI_CYC + 1);

    logic             stb_q;
    logic             armed_q;
    logic [ANG_W-1:0] hold_q;
    logic [HI_W-1:0]  hi_cnt_q;
    logic [BC_W-1:0]  busy_cnt_q;
    logic             rise, fall, start;

    // Edge detection on the sampled strobe level.
    always_comb begin
        rise  = strobe_i && !stb_q;
        fall  = !strobe_i && stb_q;
        start = fall && armed_q && (hi_cnt_q >= HI_W'(MIN_HI_CYC));
        load_o = busy_o && (busy_cnt_q == BC_W'(BUSY_CYC - 1));
    end

    // Registers the previous strobe level.
    always_ff @(posedge clk) begin
        if (!rst_n) stb_q <= 1'b0;
        else        stb_q <= strobe_i;
    end

    // Captures the angle and arms the pulse when idle; flags overrun when busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q    <= '0;
            armed_q   <= 1'b0;
            overrun_o <= 1'b0;
        end else if (rise) begin
            if (busy_o) begin
                armed_q   <= 1'b0;
                overrun_o <= 1'b1;
            end else begin
                armed_q <= 1'b1;
                hold_q  <= angle_i;
            end
        end else if (fall) begin
            armed_q <= 1'b0;
        end
    end

    // Counts high cycles of the current pulse, saturating at the minimum.
    always_ff @(posedge clk) begin
        if (!rst_n)                                          hi_cnt_q <= '0;
        else if (rise)                                       hi_cnt_q <= HI_W'(1);
        else if (strobe_i && hi_cnt_q < HI_W'(MIN_HI_CYC))   hi_cnt_q <= hi_cnt_q + HI_W'(1);
    end

    // Runs the busy interval and hands the held angle to the table.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_o     <= 1'b0;
            busy_cnt_q <= '0;
            conv_ang_o <= '0;
        end else if (start) begin
            busy_o     <= 1'b1;
            busy_cnt_q <= '0;
            conv_ang_o <= hold_q;
        end else if (busy_o) begin
            if (load_o) busy_o <= 1'b0;
            else        busy_cnt_q <= busy_cnt_q + BC_W'(1);
        end
    end

    initial begin
        assert (BUSY_CYC >= 2 && MIN_HI_CYC >= 1);
    end

    AST_BUSY_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> ($past(stb_q) && !$past(strobe_i)));              // R3
    AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (busy_cnt_q < BC_W'(BUSY_CYC)));                          // R3
    AST_NARROW_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        (fall && !busy_o && hi_cnt_q < HI_W'(MIN_HI_CYC)) |=> !busy_o);      // R4
    AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(overrun_o) |-> overrun_o);                                     // R5
    AST_ANGLE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> $stable(conv_ang_o));                  // R5
endmodule

// File: rtl/rot_sincos.sv
`timescale 1ns/1ps
// Module: rot_sincos
// Registered sine/cosine lookup from a quarter-wave table indexed by the
// low angle bits; the top two bits pick quadrant symmetry and sign.
// Assumes ANG_W >= 3; table values are round(FULL*sin) for one quadrant.
module rot_sincos
    import rot_pkg::*;
#(
    parameter int ANG_W  = 12,
    parameter int COEF_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ANG_W-1:0]         ang_i,
    output logic signed [COEF_W-1:0] sin_o,
    output logic signed [COEF_W-1:0] cos_o
);
    localparam int  IDX_W = ANG_W - 2;
    localparam int  DEPTH = 1 << IDX_W;
    localparam int  FULL  = (1 << (COEF_W - 1)) - 1;
    localparam real PI    = 3.14159265358979323846;

    logic signed [COEF_W-1:0] qtab [DEPTH];
    logic [IDX_W-1:0]         idx, idx_mir;
    quad_e                    quad;
    logic signed [COEF_W-1:0] s_mag, c_mag, s_nx, c_nx;

    // One table entry per quarter-wave step.
    for (genvar i = 0; i < DEPTH; i++) begin : gen_tab
        localparam real PH = PI * real'(i) / (2.0 * real'(DEPTH));
        assign qtab[i] = COEF_W'($rtoi(real'(FULL) * $sin(PH) + 0.5));
    end

    // Quadrant folding of the angle into table magnitudes and signs.
    always_comb begin
        idx     = ang_i[IDX_W-1:0];
        idx_mir = ~idx + IDX_W'(1);
        quad    = quad_e'(ang_i[ANG_W-1 -: 2]);
        s_mag   = qtab[idx];
        c_mag   = (idx == '0) ? COEF_W'(FULL) : qtab[idx_mir];
        unique case (quad)
            QUAD_0:   begin s_nx =  s_mag; c_nx =  c_mag; end
            QUAD_90:  begin s_nx =  c_mag; c_nx = -s_mag; end
            QUAD_180: begin s_nx = -s_mag; c_nx = -c_mag; end
            default:  begin s_nx = -c_mag; c_nx =  s_mag; end
        endcase
    end

    // Registers the looked-up pair.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sin_o <= '0;
            cos_o <= COEF_W'(FULL);
        end else begin
            sin_o <= s_nx;
            cos_o <= c_nx;
        end
    end

    AST_COEF_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (sin_o != {1'b1, {(COEF_W-1){1'b0}}}) && (cos_o != {1'b1, {(COEF_W-1){1'b0}}})); // R7
endmodule

// File: rtl/rot_mult.sv
`timescale 1ns/1ps
// Module: rot_mult
// Two-stage rotation datapath: stage 1 forms the four products, stage 2
// sums, rounds to nearest and saturates. Coefficients are Q1.(COEF_W-1).
module rot_mult #(
    parameter int DATA_W = 16,
    parameter int COEF_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid_i,
    input  logic signed [DATA_W-1:0] d_i,
    input  logic signed [DATA_W-1:0] q_i,
    input  logic signed [COEF_W-1:0] sin_i,
    input  logic signed [COEF_W-1:0] cos_i,
    output logic                     out_valid_o,
    output logic signed [DATA_W-1:0] d_o,
    output logic signed [DATA_W-1:0] q_o
);
    localparam int PW = DATA_W + COEF_W;
    localparam int SW = PW + 1;
    localparam logic signed [SW-1:0] RND  = SW'(1) <<< (COEF_W - 2);
    localparam logic signed [SW-1:0] MAXV = SW'((1 << (DATA_W - 1)) - 1);
    localparam logic signed [SW-1:0] MINV = -MAXV - SW'(1);

    logic signed [PW-1:0] p_dc, p_qs, p_ds, p_qc;
    logic                 v1_q;
    logic signed [SW-1:0] sum_d, sum_q, rnd_d, rnd_q;
    logic [1:0]           age_q;

    // Clamps a rounded sum to the output range.
    function automatic logic signed [DATA_W-1:0] clamp(input logic signed [SW-1:0] x);
        if (x > MAXV)      return DATA_W'(MAXV);
        else if (x < MINV) return DATA_W'(MINV);
        else               return DATA_W'(x);
    endfunction

    // Stage 1: the four products.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_dc <= '0; p_qs <= '0; p_ds <= '0; p_qc <= '0;
            v1_q <= 1'b0;
        end else begin
            p_dc <= d_i * cos_i;
            p_qs <= q_i * sin_i;
            p_ds <= d_i * sin_i;
            p_qc <= q_i * cos_i;
            v1_q <= in_valid_i;
        end
    end

    // Sums and round-to-nearest scaling.
    always_comb begin
        sum_d = SW'(p_dc) - SW'(p_qs);
        sum_q = SW'(p_ds) + SW'(p_qc);
        rnd_d = (sum_d + RND) >>> (COEF_W - 1);
        rnd_q = (sum_q + RND) >>> (COEF_W - 1);
    end

    // Stage 2: saturated outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            d_o <= '0; q_o <= '0; out_valid_o <= 1'b0;
        end else begin
            d_o <= clamp(rnd_d);
            q_o <= clamp(rnd_q);
            out_valid_o <= v1_q;
        end
    end

    // Cycles since reset, for the latency check.
    always_ff @(posedge clk) begin
        if (!rst_n)              age_q <= 2'd0;
        else if (age_q != 2'd3)  age_q <= age_q + 2'd1;
    end

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd3) |-> (out_valid_o == $past(in_valid_i, 2)));          // R9
endmodule

// File: rtl/park_rotator.sv
`timescale 1ns/1ps
// Module: park_rotator (top)
// Strobe-loaded angle rotator: holds sine/cosine coefficients that change
// only when a setup interval ends, and rotates every input sample by them.
// Assumes strobe_i and the sample inputs are synchronous to clk.
module park_rotator #(
    parameter int ANG_W      = 12,
    parameter int DATA_W     = 16,
    parameter int COEF_W     = 16,
    parameter int BUSY_CYC   = 400,
    parameter int MIN_HI_CYC = 20
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ANG_W-1:0]         angle_i,
    input  logic                     strobe_i,
    output logic                     busy_o,
    output logic                     overrun_o,
    input  logic                     in_valid_i,
    input  logic signed [DATA_W-1:0] d_i,
    input  logic signed [DATA_W-1:0] q_i,
    output logic                     out_valid_o,
    output logic signed [DATA_W-1:0] d_o,
    output logic signed [DATA_W-1:0] q_o
);
    localparam int FULL = (1 << (COEF_W - 1)) - 1;

    logic [ANG_W-1:0]         conv_ang;
    logic                     load;
    logic signed [COEF_W-1:0] sin_nx, cos_nx, sin_act, cos_act;

    rot_strobe_ctrl #(.ANG_W(ANG_W), .BUSY_CYC(BUSY_CYC), .MIN_HI_CYC(MIN_HI_CYC)) i_ctrl (
        .clk(clk), .rst_n(rst_n), .angle_i(angle_i), .strobe_i(strobe_i),
        .conv_ang_o(conv_ang), .busy_o(busy_o), .load_o(load), .overrun_o(overrun_o)
    );

    rot_sincos #(.ANG_W(ANG_W), .COEF_W(COEF_W)) i_sincos (
        .clk(clk), .rst_n(rst_n), .ang_i(conv_ang), .sin_o(sin_nx), .cos_o(cos_nx)
    );

    // Active coefficients switch only at the end of the setup interval.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sin_act <= '0;
            cos_act <= COEF_W'(FULL);
        end else if (load) begin
            sin_act <= sin_nx;
            cos_act <= cos_nx;
        end
    end

    rot_mult #(.DATA_W(DATA_W), .COEF_W(COEF_W)) i_mult (
        .clk(clk), .rst_n(rst_n), .in_valid_i(in_valid_i), .d_i(d_i), .q_i(q_i),
        .sin_i(sin_act), .cos_i(cos_act),
        .out_valid_o(out_valid_o), .d_o(d_o), .q_o(q_o)
    );

    AST_COEF_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> ($stable(sin_act) && $stable(cos_act)));                  // R6
    AST_COEF_CHANGE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(sin_act) || !$stable(cos_act)) |-> $fell(busy_o));         // R6
endmodule

// File: tb/test_park_rotator.sv
`timescale 1ns/1ps
module test_park_rotator;
    localparam int BUSY  = 400;
    localparam int MINHI = 20;
    localparam real PI   = 3.14159265358979323846;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [11:0] angle_i = '0;
    logic strobe_i = 1'b0;
    logic in_valid_i = 1'b0;
    logic signed [15:0] d_i = '0, q_i = '0;
    logic busy_o, overrun_o, out_valid_o;
    logic signed [15:0] d_o, q_o;
    int checks = 0, errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    park_rotator #(.BUSY_CYC(BUSY), .MIN_HI_CYC(MINHI)) i_park_rotator (
        .clk(clk), .rst_n(rst_n), .angle_i(angle_i), .strobe_i(strobe_i),
        .busy_o(busy_o), .overrun_o(overrun_o), .in_valid_i(in_valid_i),
        .d_i(d_i), .q_i(q_i), .out_valid_o(out_valid_o), .d_o(d_o), .q_o(q_o)
    );

    function automatic int rq(real x);
        if (x >= 0.0) return $rtoi(x + 0.5);
        return -$rtoi(-x + 0.5);
    endfunction

    function automatic real ph_of(int a);
        return 2.0 * PI * real'(a) / 4096.0;
    endfunction

    function automatic int expect_rot(int d, int q, real ph, bit want_q);
        longint c, s, sum, r;
        c = rq($cos(ph) * 32767.0);
        s = rq($sin(ph) * 32767.0);
        sum = want_q ? (longint'(d) * s + longint'(q) * c) : (longint'(d) * c - longint'(q) * s);
        r = (sum + 16384) >>> 15;
        if (r > 32767) r = 32767;
        if (r < -32768) r = -32768;
        return int'(r);
    endfunction

    task automatic chk(string req, string what, int act, int exp, int tol);
        checks++;
        if (act > exp + tol || act < exp - tol) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Pulse strobe for 'width' sampled edges; optionally change angle after the first.
    task automatic pulse(int ang, int width, int late_ang);
        @(negedge clk);
        angle_i = 12'(ang); strobe_i = 1'b1;
        for (int i = 0; i < width; i++) begin
            @(negedge clk);
            if (late_ang >= 0) angle_i = 12'(late_ang);
        end
        strobe_i = 1'b0;
    endtask

    // Accepted load: checks busy rise timing and exact length (R3).
    task automatic load(int ang, int late_ang);
        int n = 0;
        pulse(ang, MINHI + 2, late_ang);
        @(negedge clk);
        chk("R3", "busy after falling edge", int'(busy_o), 1, 0);
        while (busy_o && n < BUSY + 10) begin
            n++;
            @(negedge clk);
        end
        chk("R3", "busy length", n, BUSY, 0);
    endtask

    // Rotate one sample and check after two cycles.
    task automatic rot(int d, int q, real ph, string req);
        @(negedge clk);
        d_i = 16'(d); q_i = 16'(q); in_valid_i = 1'b1;
        @(negedge clk);
        in_valid_i = 1'b0;
        @(negedge clk);
        chk(req, "out valid", int'(out_valid_o), 1, 0);
        chk(req, "d out", int'(d_o), expect_rot(d, q, ph, 1'b0), 2);
        chk(req, "q out", int'(q_o), expect_rot(d, q, ph, 1'b1), 2);
    endtask

    task automatic t_reset();
        chk("R1", "busy after reset", int'(busy_o), 0, 0);
        chk("R1", "overrun after reset", int'(overrun_o), 0, 0);
        chk("R1", "valid after reset", int'(out_valid_o), 0, 0);
        rot(1000, -2000, 0.0, "R1");
    endtask

    task automatic t_quadrants();
        int angs [6] = '{1024, 2048, 3072, 512, 100, 3500};
        foreach (angs[k]) begin
            load(angs[k], -1);
            rot(12000, 5000, ph_of(angs[k]), "R7");
            rot(-7000, 9000, ph_of(angs[k]), "R7");
        end
    endtask

    task automatic t_capture();
        load(700, 2900);
        rot(10000, -3000, ph_of(700), "R2");
    endtask

    task automatic t_narrow();
        load(0, -1);
        pulse(1500, MINHI - 1, -1);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk("R4", "busy after short pulse", int'(busy_o), 0, 0);
        end
        rot(8000, 8000, 0.0, "R4");
        load(1500, -1);
        rot(8000, 8000, ph_of(1500), "R4");
    endtask

    task automatic t_overrun_lockout();
        load(0, -1);
        pulse(1024, MINHI + 2, -1);
        @(negedge clk);
        chk("R6", "busy during setup", int'(busy_o), 1, 0);
        rot(5000, 2000, 0.0, "R6");
        pulse(2048, MINHI + 2, -1);
        @(negedge clk);
        chk("R5", "overrun set", int'(overrun_o), 1, 0);
        while (busy_o) @(negedge clk);
        rot(5000, 2000, ph_of(1024), "R6");
        for (int i = 0; i < 5; i++) @(negedge clk);
        chk("R5", "no conversion from ignored pulse", int'(busy_o), 0, 0);
        rot(5000, 2000, ph_of(1024), "R5");
        load(300, -1);
        chk("R5", "overrun still set", int'(overrun_o), 1, 0);
    endtask

    task automatic t_saturate();
        load(512, -1);
        rot(-32768, -32768, ph_of(512), "R8");
        rot(32767, 32767, ph_of(512), "R8");
        chk("R8", "q saturated low", expect_rot(-32768, -32768, ph_of(512), 1'b1), -32768, 0);
    endtask

    task automatic t_valid();
        @(negedge clk);
        d_i = 16'sd100; q_i = 16'sd0; in_valid_i = 1'b1;
        @(negedge clk);
        in_valid_i = 1'b0;
        chk("R9", "valid after one cycle", int'(out_valid_o), 0, 0);
        @(negedge clk);
        chk("R9", "valid after two cycles", int'(out_valid_o), 1, 0);
        @(negedge clk);
        chk("R9", "valid after three cycles", int'(out_valid_o), 0, 0);
    endtask

    task automatic t_reverse();
        load(4096 - 300, -1);
        rot(15000, -4000, -ph_of(300), "R10");
        rot(-2500, 11000, -ph_of(300), "R10");
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_valid();
        t_quadrants();
        t_capture();
        t_narrow();
        t_saturate();
        t_reverse();
        t_overrun_lockout();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule